// File: doc/BRIEF.md
# DMA Bus Configuration and Lane Steering Unit

This unit sits at the edge of a 16-bit multiplexed address/data bus. It owns a single configuration byte. After a hardware reset, the first register write the host issues is taken as that byte, whatever address it carries. Once the byte is loaded, the unit opens the register path, and later host writes and reads pass through to the DMA register file.

The configuration byte controls three things:

- **Incoming lane.** When swapping is enabled, it picks which byte lane of the bus incoming DMA data comes from, using address bit 0.
- **Outgoing data.** It copies outgoing 8-bit DMA data onto both byte lanes.
- **Address window.** It sets which 5-bit window of the multiplexed address lines forms the internal DMA register address.

The unit also decodes the interrupt-acknowledge style into a one-hot output. It flags a reserved acknowledge code with a sticky error.

A soft reset input exists for the surrounding channel logic. It only clears the registered read-data path and never touches the configuration.

Top module: `buscfg_lane_steer`

## Requirements
- R1: After hardware reset (`hw_rst_n` low, asynchronous), `cfg_q` is 0x00, `cfg_pending` is 1, `cfg_error` is 0, and `rd_valid` and `rd_data` are 0.
- R2: While `cfg_pending` is 1, a `reg_wr` at any `reg_ad` loads `reg_wdata` (all eight bits, reserved bits 5:3 included) into `cfg_q` on that clock edge and clears `cfg_pending`. That write is not forwarded on `fwd_wr`.
- R3: While `cfg_pending` is 0, `fwd_wr` follows `reg_wr`, `fwd_wdata` equals `reg_wdata`, and `cfg_q` keeps its value.
- R4: While `cfg_pending` is 1, `fwd_rd` and `fwd_wr` stay 0. Once it is 0, `fwd_rd` follows `reg_rd`.
- R5: `soft_rst` has no effect on `cfg_q`, `cfg_pending` or `cfg_error`.
- R6: With `cfg_q[7]` = 0, read data is taken from `dma_bus_in[7:0]` and bits 15:8 are ignored.
- R7: With `cfg_q[7]` = 1 and `cfg_q[6]` = 1, `dma_rd_a0` = 0 takes bits 7:0 and `dma_rd_a0` = 1 takes bits 15:8.
- R8: With `cfg_q[7]` = 1 and `cfg_q[6]` = 0, `dma_rd_a0` = 0 takes bits 15:8 and `dma_rd_a0` = 1 takes bits 7:0.
- R9: `dma_bus_out` always equals `{dma_wr_data, dma_wr_data}`.
- R10: `ack_sel` decodes `cfg_q[2:1]` as follows: 00 gives 3'b001 (status), 01 gives 3'b010 (pulsed), 11 gives 3'b100 (double-pulsed), and 10 (reserved) gives 3'b000.
- R11: Loading a configuration byte with bits 2:1 = 10 sets `cfg_error`. It stays set until the next hardware reset.
- R12: `fwd_addr` is `reg_ad[4:0]` when `cfg_q[0]` = 1, and `reg_ad[5:1]` when `cfg_q[0]` = 0.
- R13: On a clock edge with `dma_rd_valid` high and `soft_rst` low, the selected byte is registered into `rd_data` and `rd_valid` is 1 for that cycle. On an edge without `dma_rd_valid`, `rd_valid` returns to 0 and `rd_data` holds. On an edge with `soft_rst` high, both are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous channel reset; read path only |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_ad | input | 16 | Latched address phase of the multiplexed bus |
| reg_wdata | input | 8 | Host write data |
| fwd_wr | output | 1 | Forwarded register write |
| fwd_rd | output | 1 | Forwarded register read |
| fwd_addr | output | 5 | Decoded DMA register address |
| fwd_wdata | output | 8 | Forwarded write data |
| cfg_q | output | 8 | Configuration byte |
| cfg_pending | output | 1 | High until the configuration write is taken |
| cfg_error | output | 1 | Sticky reserved-acknowledge-code flag |
| ack_sel | output | 3 | One-hot acknowledge style: status, pulsed, double-pulsed |
| dma_rd_valid | input | 1 | Incoming DMA byte present on the bus |
| dma_rd_a0 | input | 1 | Address bit 0 of the incoming transfer |
| dma_bus_in | input | 16 | Bus data for incoming DMA |
| rd_data | output | 8 | Registered steered byte |
| rd_valid | output | 1 | One-cycle valid for `rd_data` |
| dma_wr_data | input | 8 | Outgoing DMA byte |
| dma_bus_out | output | 16 | Outgoing byte on both lanes |

## Verification
The bench targets the following corner cases. A design that got each one wrong would show the symptom given.

- **First write at an odd address.** A design that decodes the address for capture would miss the first write or forward it.
- **Write attempted right after capture.** A design that is not write-once would overwrite the byte.
- **Both swap polarities at both values of address bit 0.** Each is driven with distinct high and low bytes, so a swapped mux shows up as wrong data.
- **Swap disabled with a busy upper lane.** Leaking bits 15:8 would be visible.
- **Soft reset around capture and around reads.** A design that clears the configuration on soft reset would reopen the capture window and drop the error flag.
- **Address patterns with bit 0 and bit 5 different.** An off-by-one window shows up as a wrong forwarded address.

// File: rtl/buscfg_lane_steer.sv
module buscfg_lane_steer #(
  parameter int BUS_W   = 16,
  parameter int RADDR_W = 5
) (
  input  logic               clk,
  input  logic               hw_rst_n,
  input  logic               soft_rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [BUS_W-1:0]   reg_ad,
  input  logic [BUS_W/2-1:0] reg_wdata,
  output logic               fwd_wr,
  output logic               fwd_rd,
  output logic [RADDR_W-1:0] fwd_addr,
  output logic [BUS_W/2-1:0] fwd_wdata,
  output logic [BUS_W/2-1:0] cfg_q,
  output logic               cfg_pending,
  output logic               cfg_error,
  output logic [2:0]         ack_sel,
  input  logic               dma_rd_valid,
  input  logic               dma_rd_a0,
  input  logic [BUS_W-1:0]   dma_bus_in,
  output logic [BUS_W/2-1:0] rd_data,
  output logic               rd_valid,
  input  logic [BUS_W/2-1:0] dma_wr_data,
  output logic [BUS_W-1:0]   dma_bus_out
);
  localparam int LANE_W = BUS_W / 2;

  logic               take_cfg;
  logic               swap_en, swap_sel, shift_right;
  logic [1:0]         ack_code;
  logic               pick_high;
  logic [LANE_W-1:0]  lane_byte;

  assign take_cfg    = cfg_pending && reg_wr;
  assign swap_en     = cfg_q[7];
  assign swap_sel    = cfg_q[6];
  assign ack_code    = cfg_q[2:1];
  assign shift_right = cfg_q[0];

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      cfg_q       <= '0;
      cfg_pending <= 1'b1;
      cfg_error   <= 1'b0;
    end else if (take_cfg) begin
      cfg_q       <= reg_wdata;
      cfg_pending <= 1'b0;
      cfg_error   <= cfg_error | (reg_wdata[2:1] == 2'b10);
    end
  end

  assign fwd_wr    = reg_wr && !cfg_pending;
  assign fwd_rd    = reg_rd && !cfg_pending;
  assign fwd_wdata = reg_wdata;
  assign fwd_addr  = shift_right ? reg_ad[RADDR_W-1:0] : reg_ad[RADDR_W:1];

  always_comb begin
    unique case (ack_code)
      2'b00:   ack_sel = 3'b001;
      2'b01:   ack_sel = 3'b010;
      2'b11:   ack_sel = 3'b100;
      default: ack_sel = 3'b000;
    endcase
  end

  assign pick_high = swap_en && (swap_sel ? dma_rd_a0 : !dma_rd_a0);
  assign lane_byte = pick_high ? dma_bus_in[BUS_W-1:LANE_W] : dma_bus_in[LANE_W-1:0];

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (soft_rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= dma_rd_valid;
      if (dma_rd_valid) rd_data <= lane_byte;
    end
  end

  assign dma_bus_out = {dma_wr_data, dma_wr_data};
endmodule

module buscfg_lane_steer_chk (
  input logic       clk,
  input logic       hw_rst_n,
  input logic       soft_rst,
  input logic       reg_wr,
  input logic       fwd_wr,
  input logic       fwd_rd,
  input logic [7:0] cfg_q,
  input logic       cfg_pending,
  input logic       cfg_error,
  input logic [2:0] ack_sel,
  input logic       dma_rd_valid,
  input logic       rd_valid
);
  p_capture_closes_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (cfg_pending && reg_wr) |=> !cfg_pending);
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !cfg_pending |=> ($stable(cfg_q) && !cfg_pending));
  p_blocked_r4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    cfg_pending |-> (!fwd_wr && !fwd_rd));
  p_soft_keeps_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (soft_rst && !cfg_pending) |=> $stable(cfg_q));
  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $onehot0(ack_sel));
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!hw_rst_n)
    cfg_error |=> cfg_error);
  p_valid_pulse_r13: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (dma_rd_valid && !soft_rst) |=> rd_valid);
endmodule

bind buscfg_lane_steer buscfg_lane_steer_chk u_chk (
  .clk(clk), .hw_rst_n(hw_rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
  .fwd_wr(fwd_wr), .fwd_rd(fwd_rd), .cfg_q(cfg_q), .cfg_pending(cfg_pending),
  .cfg_error(cfg_error), .ack_sel(ack_sel), .dma_rd_valid(dma_rd_valid),
  .rd_valid(rd_valid)
);

// File: tb/sim_buscfg_lane_steer.sv
module sim_buscfg_lane_steer;
  logic        clk = 0;
  logic        hw_rst_n = 0, soft_rst = 0, reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_ad = 0;
  logic [7:0]  reg_wdata = 0;
  logic        fwd_wr, fwd_rd, cfg_pending, cfg_error, rd_valid;
  logic [4:0]  fwd_addr;
  logic [7:0]  fwd_wdata, cfg_q, rd_data;
  logic [2:0]  ack_sel;
  logic        dma_rd_valid = 0, dma_rd_a0 = 0;
  logic [15:0] dma_bus_in = 0, dma_bus_out;
  logic [7:0]  dma_wr_data = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_cfg, m_rdat;
  bit         m_pend, m_err, m_rval;

  always #5 clk = ~clk;

  buscfg_lane_steer u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string lane_tag();
    if (!m_cfg[7]) return "R6";
    return m_cfg[6] ? "R7" : "R8";
  endfunction

  task automatic compare();
    logic [2:0] exp_ack;
    case (m_cfg[2:1])
      2'b00: exp_ack = 3'b001;
      2'b01: exp_ack = 3'b010;
      2'b11: exp_ack = 3'b100;
      default: exp_ack = 3'b000;
    endcase
    chk("R2", "cfg_q", cfg_q, m_cfg);
    chk("R2", "cfg_pending", cfg_pending, m_pend);
    chk("R11", "cfg_error", cfg_error, m_err);
    chk("R3", "fwd_wr", fwd_wr, reg_wr && !m_pend);
    chk("R4", "fwd_rd", fwd_rd, reg_rd && !m_pend);
    chk("R3", "fwd_wdata", fwd_wdata, reg_wdata);
    chk("R12", "fwd_addr", fwd_addr, m_cfg[0] ? reg_ad[4:0] : reg_ad[5:1]);
    chk("R10", "ack_sel", ack_sel, exp_ack);
    chk("R9", "dma_bus_out", dma_bus_out, {dma_wr_data, dma_wr_data});
    chk("R13", "rd_valid", rd_valid, m_rval);
    chk(lane_tag(), "rd_data", rd_data, m_rdat);
  endtask

  task automatic model_reset();
    m_cfg = 0; m_pend = 1; m_err = 0; m_rdat = 0; m_rval = 0;
  endtask

  task automatic tick();
    bit hi;
    #1 compare();
    @(posedge clk);
    hi = m_cfg[7] && (m_cfg[6] ? dma_rd_a0 : !dma_rd_a0);
    if (soft_rst) begin
      m_rval = 0; m_rdat = 0;
    end else begin
      m_rval = dma_rd_valid;
      if (dma_rd_valid) m_rdat = hi ? dma_bus_in[15:8] : dma_bus_in[7:0];
    end
    if (m_pend && reg_wr) begin
      m_cfg = reg_wdata; m_pend = 0;
      if (reg_wdata[2:1] == 2'b10) m_err = 1;
    end
    #1 compare();
  endtask

  task automatic hw_reset();
    #2 hw_rst_n = 0; model_reset();
    #1 compare();
    chk("R1", "reset pending", cfg_pending, 1);
    chk("R1", "reset cfg", cfg_q, 0);
    chk("R1", "reset rd_valid", rd_valid, 0);
    @(posedge clk); #2 hw_rst_n = 1;
  endtask

  task automatic wr(input logic [15:0] ad, input logic [7:0] d);
    reg_wr = 1; reg_ad = ad; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic dma_rd(input bit a0, input logic [15:0] bus);
    dma_rd_valid = 1; dma_rd_a0 = a0; dma_bus_in = bus; tick();
    dma_rd_valid = 0; tick();
  endtask

  task automatic mix(input int n);
    for (int i = 0; i < n; i++) begin
      reg_ad = 16'(i * 16'h1357 + 16'h21);
      reg_rd = i[0];
      reg_wr = i[1];
      reg_wdata = 8'(i * 37);
      dma_wr_data = 8'(i * 91 + 5);
      tick();
      dma_rd(i[2], 16'(i * 16'h3c5a + 16'h0f1e));
    end
    reg_rd = 0; reg_wr = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(posedge clk); #2;
    hw_reset();
    // R4 and R5 before configuration
    reg_rd = 1; reg_ad = 16'h0003; tick(); reg_rd = 0;
    soft_rst = 1; tick(); soft_rst = 0;
    chk("R5", "pending after soft", cfg_pending, 1);
    // R2 first write at odd address, swap sel=1, shift right, status ack
    wr(16'h003F, 8'hC1);
    chk("R2", "captured", cfg_q, 8'hC1);
    wr(16'h0012, 8'h55);
    chk("R3", "write-once", cfg_q, 8'hC1);
    dma_rd(0, 16'hAB12); chk("R7", "a0=0 low", rd_data, 8'h12);
    dma_rd(1, 16'hAB12); chk("R7", "a0=1 high", rd_data, 8'hAB);
    mix(12);
    soft_rst = 1; tick(); soft_rst = 0;
    chk("R5", "cfg kept", cfg_q, 8'hC1);
    // swap sel=0, shift left, double-pulsed
    hw_reset();
    wr(16'h0000, 8'h86);
    dma_rd(0, 16'hCD34); chk("R8", "a0=0 high", rd_data, 8'hCD);
    dma_rd(1, 16'hCD34); chk("R8", "a0=1 low", rd_data, 8'h34);
    reg_ad = 16'h0021; tick(); chk("R12", "shift-left addr", fwd_addr, 5'h10);
    mix(12);
    // reserved ack code, swap off, reserved bits stored
    hw_reset();
    wr(16'h0001, 8'h3C);
    chk("R11", "error set", cfg_error, 1);
    chk("R10", "reserved ack", ack_sel, 0);
    dma_rd(1, 16'hFF77); chk("R6", "swap off", rd_data, 8'h77);
    dma_rd_valid = 1; dma_bus_in = 16'h1199; soft_rst = 1; tick();
    chk("R13", "soft clears valid", rd_valid, 0);
    soft_rst = 0; dma_rd_valid = 0; tick();
    chk("R11", "error survives soft", cfg_error, 1);
    mix(8);
    hw_reset();
    chk("R11", "error cleared", cfg_error, 0);
    wr(16'h0000, 8'h03);
    chk("R10", "pulsed", ack_sel, 3'b010);
    mix(8);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule